// File: doc/BRIEF.md
# Triangular Array Multiply-Accumulate Cell

This block is a single cell of a lower-triangular systolic array that runs an iterative relaxation-based MIMO detector. Each cell holds one entry of the working matrix, owns one signed fixed-point multiplier and one accumulator, and reuses that multiplier for four operations chosen by a mode input: loading the starting value, accumulating a broadcast matrix product, chaining a column squared norm downward, and rescaling by a column factor.

A parameter picks the cell flavour. A cell on the diagonal loads its starting value from the column broadcast, and it starts a column norm chain. An off-diagonal cell loads a fixed starting value and adds the partial sum from the cell above. A cell in the bottom row keeps one fewer fractional bit, and its partial-sum output goes to the column scale logic. Mode, first-cycle flag, cycle index and operands all pass through one input register, so every cell in a wavefront switches operation on the same edge. Each result appears on the outputs two rising edges after the inputs are presented.

Top module: `pe_tri_cell`

## Requirements
- R1: While reset is asserted, and on the first edge after it is released, `val_out` and `psum_out` are zero.
- R2: Load (mode 0): an off-diagonal cell stores the parameter `INIT_OFF`, and a diagonal cell stores `col_op`.
- R3: Multiply (mode 1): when `first` is high, the accumulator becomes the stored value minus the rounded product. When `first` is low, the rounded product is subtracted from the accumulator. The product uses `col_op` with 5 fractional bits, so the product is shifted right by 5.
- R4: In multiply mode, when `cyc_idx` equals the parameter `COL`, the cell's own stored value replaces `row_op` as the multiplier operand.
- R5: Norm (mode 2): the accumulator is squared and rounded back to the data format. A diagonal cell outputs that square on `psum_out`. An off-diagonal cell outputs the square plus `psum_in`.
- R6: Scale (mode 3): the stored value becomes the accumulator times `col_op`, where `col_op` carries 13 fractional bits, rounded back to the data format.
- R7: Data words are 14-bit signed with 8 fractional bits, or 7 when `LAST_ROW` is set. Every rescale rounds half upward: add 2^(s-1), then shift right arithmetically by s.
- R8: A result outside the 14-bit signed range saturates to 8191 or -8192 and never wraps.
- R9: With `en` low, no stored state changes, whatever mode and operands are presented.
- R10: The effect of an operation appears at the outputs on the second rising edge after it is presented, and not on the first.
- R11: `psum_out` changes only on a norm operation. `val_out` changes only on a load or scale operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Operation valid for this cycle |
| mode | input | 2 | 0 load, 1 multiply, 2 norm, 3 scale |
| first | input | 1 | First multiply cycle of an iteration |
| cyc_idx | input | IW | Multiply cycle index within the iteration |
| row_op | input | DW | Row-broadcast operand |
| col_op | input | DW | Column-broadcast operand (matrix entry, start value or scale factor) |
| psum_in | input | DW | Norm partial sum from the cell above |
| val_out | output | DW | Stored value, driven to the row broadcast |
| psum_out | output | DW | Norm partial sum to the cell below or the scale logic |

## Verification
The bound checker watches four properties on every cycle: the reset state, the load value of each flavour, that idle cycles leave the outputs untouched, and that the partial sum moves only on norm operations. For a diagonal cell it also checks that the emitted square is never negative. The arithmetic cannot be shown that way: subtraction from the stored value or from the accumulator, the switch to the own operand in the cell's column, rounding, saturation at both limits, and the narrower format of the bottom row. Only the bench's scenarios show these. They drive a diagonal cell, an off-diagonal cell and a bottom-row cell in lockstep against a model, and they check one edge early to show the two-edge latency.

// File: rtl/pe_tri_pkg.sv
package pe_tri_pkg;

  typedef enum logic [1:0] {
    PE_LOAD  = 2'd0,
    PE_MAC   = 2'd1,
    PE_NORM  = 2'd2,
    PE_SCALE = 2'd3
  } pe_op_e;

  // Internal width wide enough for any product plus carry.
  localparam int PE_WIDE = 40;

  // Round half up, then arithmetic shift right by sh.
  function automatic logic signed [PE_WIDE-1:0] pe_rnd(
    input logic signed [PE_WIDE-1:0] x,
    input int unsigned               sh
  );
    logic signed [PE_WIDE-1:0] half;
    if (sh == 0) return x;
    half = PE_WIDE'(1) << (sh - 1);
    return (x + half) >>> sh;
  endfunction

  // Saturate to a w-bit two's complement range.
  function automatic logic signed [PE_WIDE-1:0] pe_clip(
    input logic signed [PE_WIDE-1:0] x,
    input int unsigned               w
  );
    logic signed [PE_WIDE-1:0] hi;
    logic signed [PE_WIDE-1:0] lo;
    hi = (PE_WIDE'(1) << (w - 1)) - PE_WIDE'(1);
    lo = -hi - PE_WIDE'(1);
    if (x > hi) return hi;
    if (x < lo) return lo;
    return x;
  endfunction

endpackage

// File: rtl/pe_in_stage.sv
module pe_in_stage
  import pe_tri_pkg::*;
#(
  parameter int DW  = 14,
  parameter int IW  = 5,
  parameter int COL = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [1:0]           mode,
  input  logic                 first,
  input  logic [IW-1:0]        cyc_idx,
  input  logic signed [DW-1:0] row_op,
  input  logic signed [DW-1:0] col_op,
  input  logic signed [DW-1:0] psum_in,
  output logic                 en_q,
  output pe_op_e               mode_q,
  output logic                 first_q,
  output logic                 own_q,
  output logic signed [DW-1:0] row_q,
  output logic signed [DW-1:0] col_q,
  output logic signed [DW-1:0] ps_q
);

  localparam logic [IW-1:0] MY_COL = IW'(COL);

  pe_op_e              mode_nx;
  logic                first_nx;
  logic                own_nx;
  logic signed [DW-1:0] row_nx;
  logic signed [DW-1:0] col_nx;
  logic signed [DW-1:0] ps_nx;

  // Operand capture is clock-enabled by en; the valid flag loads every cycle.
  always_comb begin
    mode_nx  = mode_q;
    first_nx = first_q;
    own_nx   = own_q;
    row_nx   = row_q;
    col_nx   = col_q;
    ps_nx    = ps_q;
    if (en) begin
      mode_nx  = pe_op_e'(mode);
      first_nx = first;
      own_nx   = (cyc_idx == MY_COL);
      row_nx   = row_op;
      col_nx   = col_op;
      ps_nx    = psum_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      mode_q  <= PE_LOAD;
      first_q <= 1'b0;
      own_q   <= 1'b0;
      row_q   <= '0;
      col_q   <= '0;
      ps_q    <= '0;
    end else begin
      en_q    <= en;
      mode_q  <= mode_nx;
      first_q <= first_nx;
      own_q   <= own_nx;
      row_q   <= row_nx;
      col_q   <= col_nx;
      ps_q    <= ps_nx;
    end
  end

endmodule

// File: rtl/pe_mac.sv
module pe_mac
  import pe_tri_pkg::*;
#(
  parameter int DW       = 14,
  parameter int FRAC     = 8,
  parameter int TFRAC    = 5,
  parameter int SFRAC    = 13,
  parameter bit IS_DIAG  = 1'b0,
  parameter int INIT_OFF = 0
) (
  input  logic                 en_q,
  input  pe_op_e               mode_q,
  input  logic                 first_q,
  input  logic                 own_q,
  input  logic signed [DW-1:0] row_q,
  input  logic signed [DW-1:0] col_q,
  input  logic signed [DW-1:0] ps_q,
  input  logic signed [DW-1:0] val,
  input  logic signed [DW-1:0] acc,
  output logic                 ld_val,
  output logic                 ld_acc,
  output logic                 ld_ps,
  output logic signed [DW-1:0] val_nx,
  output logic signed [DW-1:0] acc_nx,
  output logic signed [DW-1:0] ps_nx
);

  localparam int PW = 2 * DW;
  localparam logic signed [DW-1:0] INIT_V = DW'(INIT_OFF);

  logic signed [DW-1:0]      opa;
  logic signed [DW-1:0]      opb;
  int unsigned               sh;
  logic signed [PW-1:0]      prod;
  logic signed [PE_WIDE-1:0] prod_w;
  logic signed [PE_WIDE-1:0] prod_r;
  logic signed [PE_WIDE-1:0] base_w;
  logic signed [PE_WIDE-1:0] chain_w;
  logic signed [PE_WIDE-1:0] diff_c;
  logic signed [PE_WIDE-1:0] sum_c;
  logic signed [PE_WIDE-1:0] prod_c;
  logic signed [DW-1:0]      load_v;

  // One shared multiplier: operand and shift selection per mode.
  always_comb begin
    opa = acc;
    opb = col_q;
    sh  = SFRAC;
    unique case (mode_q)
      PE_MAC: begin
        opa = own_q ? val : row_q;
        opb = col_q;
        sh  = TFRAC;
      end
      PE_NORM: begin
        opa = acc;
        opb = acc;
        sh  = FRAC;
      end
      PE_SCALE: begin
        opa = acc;
        opb = col_q;
        sh  = SFRAC;
      end
      default: begin
        opa = acc;
        opb = col_q;
        sh  = SFRAC;
      end
    endcase
  end

  assign prod   = opa * opb;
  assign prod_w = {{(PE_WIDE-PW){prod[PW-1]}}, prod};
  assign prod_r = pe_rnd(prod_w, sh);

  // Multiply-accumulate: start from the stored value on the first cycle.
  assign base_w = first_q ? {{(PE_WIDE-DW){val[DW-1]}}, val}
                          : {{(PE_WIDE-DW){acc[DW-1]}}, acc};
  assign diff_c = pe_clip(base_w - prod_r, DW);
  assign prod_c = pe_clip(prod_r, DW);

  // Flavour-specific behaviour: starting value and norm chaining.
  generate
    if (IS_DIAG) begin : g_diag
      assign load_v  = col_q;
      assign chain_w = '0;
    end else begin : g_off
      assign load_v  = INIT_V;
      assign chain_w = {{(PE_WIDE-DW){ps_q[DW-1]}}, ps_q};
    end
  endgenerate

  assign sum_c = pe_clip(prod_r + chain_w, DW);

  always_comb begin
    ld_val = 1'b0;
    ld_acc = 1'b0;
    ld_ps  = 1'b0;
    val_nx = prod_c[DW-1:0];
    acc_nx = diff_c[DW-1:0];
    ps_nx  = sum_c[DW-1:0];
    if (en_q) begin
      unique case (mode_q)
        PE_LOAD: begin
          ld_val = 1'b1;
          val_nx = load_v;
        end
        PE_MAC:   ld_acc = 1'b1;
        PE_NORM:  ld_ps  = 1'b1;
        PE_SCALE: ld_val = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/pe_state.sv
module pe_state #(
  parameter int DW = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld_val,
  input  logic                 ld_acc,
  input  logic                 ld_ps,
  input  logic signed [DW-1:0] val_nx,
  input  logic signed [DW-1:0] acc_nx,
  input  logic signed [DW-1:0] ps_nx,
  output logic signed [DW-1:0] val,
  output logic signed [DW-1:0] acc,
  output logic signed [DW-1:0] ps
);

  logic signed [DW-1:0] val_d;
  logic signed [DW-1:0] acc_d;
  logic signed [DW-1:0] ps_d;

  always_comb begin
    val_d = ld_val ? val_nx : val;
    acc_d = ld_acc ? acc_nx : acc;
    ps_d  = ld_ps  ? ps_nx  : ps;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val <= '0;
      acc <= '0;
      ps  <= '0;
    end else begin
      val <= val_d;
      acc <= acc_d;
      ps  <= ps_d;
    end
  end

endmodule

// File: rtl/pe_tri_cell.sv
module pe_tri_cell
  import pe_tri_pkg::*;
#(
  parameter int DW        = 14,
  parameter int IW        = 5,
  parameter int COL       = 0,
  parameter bit IS_DIAG   = 1'b0,
  parameter bit LAST_ROW  = 1'b0,
  parameter int FRAC_BODY = 8,
  parameter int FRAC_LAST = 7,
  parameter int TFRAC     = 5,
  parameter int SFRAC     = 13,
  parameter int INIT_OFF  = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [1:0]           mode,
  input  logic                 first,
  input  logic [IW-1:0]        cyc_idx,
  input  logic signed [DW-1:0] row_op,
  input  logic signed [DW-1:0] col_op,
  input  logic signed [DW-1:0] psum_in,
  output logic signed [DW-1:0] val_out,
  output logic signed [DW-1:0] psum_out
);

  localparam int FRAC = LAST_ROW ? FRAC_LAST : FRAC_BODY;

  logic                 en_q;
  pe_op_e               mode_q;
  logic                 first_q;
  logic                 own_q;
  logic signed [DW-1:0] row_q;
  logic signed [DW-1:0] col_q;
  logic signed [DW-1:0] ps_q;
  logic                 ld_val;
  logic                 ld_acc;
  logic                 ld_ps;
  logic signed [DW-1:0] val_nx;
  logic signed [DW-1:0] acc_nx;
  logic signed [DW-1:0] ps_nx;
  logic signed [DW-1:0] val_r;
  logic signed [DW-1:0] acc_r;
  logic signed [DW-1:0] ps_r;

  pe_in_stage #(.DW(DW), .IW(IW), .COL(COL)) u_in (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .first(first),
    .cyc_idx(cyc_idx), .row_op(row_op), .col_op(col_op), .psum_in(psum_in),
    .en_q(en_q), .mode_q(mode_q), .first_q(first_q), .own_q(own_q),
    .row_q(row_q), .col_q(col_q), .ps_q(ps_q)
  );

  pe_mac #(
    .DW(DW), .FRAC(FRAC), .TFRAC(TFRAC), .SFRAC(SFRAC),
    .IS_DIAG(IS_DIAG), .INIT_OFF(INIT_OFF)
  ) u_mac (
    .en_q(en_q), .mode_q(mode_q), .first_q(first_q), .own_q(own_q),
    .row_q(row_q), .col_q(col_q), .ps_q(ps_q), .val(val_r), .acc(acc_r),
    .ld_val(ld_val), .ld_acc(ld_acc), .ld_ps(ld_ps),
    .val_nx(val_nx), .acc_nx(acc_nx), .ps_nx(ps_nx)
  );

  pe_state #(.DW(DW)) u_st (
    .clk(clk), .rst_n(rst_n), .ld_val(ld_val), .ld_acc(ld_acc), .ld_ps(ld_ps),
    .val_nx(val_nx), .acc_nx(acc_nx), .ps_nx(ps_nx),
    .val(val_r), .acc(acc_r), .ps(ps_r)
  );

  assign val_out  = val_r;
  assign psum_out = ps_r;

endmodule

// File: rtl/pe_tri_cell_chk.sv
module pe_tri_cell_chk #(
  parameter int DW       = 14,
  parameter bit IS_DIAG  = 1'b0,
  parameter int INIT_OFF = 0
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 en_q,
  input logic [1:0]           mode_q,
  input logic signed [DW-1:0] col_q,
  input logic signed [DW-1:0] val_out,
  input logic signed [DW-1:0] psum_out
);

  localparam logic signed [DW-1:0] INIT_V = DW'(INIT_OFF);

  // R1: outputs are clear on the first edge after reset release
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (val_out == '0 && psum_out == '0));

  // R9: an idle cycle leaves both outputs untouched
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> ($stable(val_out) && $stable(psum_out)));

  // R11: the partial sum moves only on a norm operation
  a_r11_psum_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && mode_q != 2'd2) |=> $stable(psum_out));

  generate
    if (IS_DIAG) begin : g_diag
      // R2: diagonal cell loads the column broadcast
      a_r2_diag_load: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && mode_q == 2'd0) |=> (val_out == $past(col_q)));
      // R5: a diagonal cell emits a bare square, never negative
      a_r5_square_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && mode_q == 2'd2) |=> (psum_out >= 0));
    end else begin : g_off
      // R2: off-diagonal cell loads its fixed starting value
      a_r2_off_load: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && mode_q == 2'd0) |=> (val_out == INIT_V));
    end
  endgenerate

endmodule

bind pe_tri_cell pe_tri_cell_chk #(
  .DW(DW), .IS_DIAG(IS_DIAG), .INIT_OFF(INIT_OFF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .mode_q(mode_q), .col_q(col_q),
  .val_out(val_out), .psum_out(psum_out)
);

// File: tb/pe_tri_cell_test.sv
module pe_tri_cell_test;

  localparam int DW = 14;
  localparam int IW = 5;

  logic clk;
  logic rst_n;
  logic en;
  logic [1:0] mode;
  logic first;
  logic [IW-1:0] idx;
  logic signed [DW-1:0] row;
  logic signed [DW-1:0] col;
  logic signed [DW-1:0] psin;
  logic signed [DW-1:0] v0, v1, v2, p0, p1, p2;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // Cell 0: off-diagonal, column 2. Cell 1: diagonal, column 1. Cell 2: bottom row, column 0.
  pe_tri_cell #(.COL(2), .IS_DIAG(1'b0), .LAST_ROW(1'b0), .INIT_OFF(64)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .first(first), .cyc_idx(idx),
    .row_op(row), .col_op(col), .psum_in(psin), .val_out(v0), .psum_out(p0));
  pe_tri_cell #(.COL(1), .IS_DIAG(1'b1), .LAST_ROW(1'b0), .INIT_OFF(0)) uut_diag (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .first(first), .cyc_idx(idx),
    .row_op(row), .col_op(col), .psum_in(psin), .val_out(v1), .psum_out(p1));
  pe_tri_cell #(.COL(0), .IS_DIAG(1'b0), .LAST_ROW(1'b1), .INIT_OFF(-96)) uut_last (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .first(first), .cyc_idx(idx),
    .row_op(row), .col_op(col), .psum_in(psin), .val_out(v2), .psum_out(p2));

  initial clk = 1'b0;
  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Reference model state per cell.
  int     k_diag [3] = '{0, 1, 0};
  int     k_frac [3] = '{8, 8, 7};
  int     k_col  [3] = '{2, 1, 0};
  longint k_init [3] = '{64, 0, -96};
  longint mv [3];
  longint ma [3];
  longint mp [3];

  typedef struct {
    int     due;
    longint v0, v1, v2, p0, p1, p2;
    string  tag;
  } exp_t;
  exp_t sb[$];

  function automatic longint sat14(longint x);
    if (x > 8191) return 8191;
    if (x < -8192) return -8192;
    return x;
  endfunction

  function automatic longint rshr(longint x, int s);
    longint h;
    h = longint'(1) <<< (s - 1);
    return (x + h) >>> s;
  endfunction

  function automatic exp_t snap(int due, string tag);
    exp_t e;
    e.due = due; e.tag = tag;
    e.v0 = mv[0]; e.v1 = mv[1]; e.v2 = mv[2];
    e.p0 = mp[0]; e.p1 = mp[1]; e.p2 = mp[2];
    return e;
  endfunction

  task automatic apply(input logic [1:0] m, input logic f, input int ix,
                       input longint r, input longint c, input longint ps,
                       input string tag);
    @(posedge clk); #1;
    en = 1'b1; mode = m; first = f; idx = IW'(ix);
    row = DW'(r); col = DW'(c); psin = DW'(ps);
    // R10: nothing visible after only one edge
    sb.push_back(snap(cyc + 1, {"R10 pre ", tag}));
    for (int k = 0; k < 3; k++) begin
      longint a;
      longint pr;
      case (m)
        2'd0: mv[k] = (k_diag[k] != 0) ? c : k_init[k];
        2'd1: begin
          a  = (ix == k_col[k]) ? mv[k] : r;
          pr = rshr(a * c, 5);
          ma[k] = sat14((f ? mv[k] : ma[k]) - pr);
        end
        2'd2: begin
          pr = rshr(ma[k] * ma[k], k_frac[k]);
          mp[k] = sat14(pr + ((k_diag[k] != 0) ? 0 : ps));
        end
        default: begin
          pr = rshr(ma[k] * c, 13);
          mv[k] = sat14(pr);
        end
      endcase
    end
    sb.push_back(snap(cyc + 2, tag));
  endtask

  task automatic idle(input logic [1:0] m, input longint ps, input string tag);
    @(posedge clk); #1;
    en = 1'b0; mode = m; first = 1'b1; idx = '0;
    row = 14'sd1234; col = 14'sd4000; psin = DW'(ps);
    sb.push_back(snap(cyc + 1, tag));
    sb.push_back(snap(cyc + 2, tag));
  endtask

  task automatic cmp(input longint act, input longint expv, input string what, input string tag);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  // Monitor: pops expected items when they fall due.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      cmp(longint'(v0), e.v0, "val(off)",  e.tag);
      cmp(longint'(v1), e.v1, "val(diag)", e.tag);
      cmp(longint'(v2), e.v2, "val(last)", e.tag);
      cmp(longint'(p0), e.p0, "psum(off)",  e.tag);
      cmp(longint'(p1), e.p1, "psum(diag)", e.tag);
      cmp(longint'(p2), e.p2, "psum(last)", e.tag);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 3; k++) begin mv[k] = 0; ma[k] = 0; mp[k] = 0; end
    rst_n = 1'b0; en = 1'b0; mode = 2'd0; first = 1'b0; idx = '0;
    row = '0; col = '0; psin = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    sb.push_back(snap(cyc, "R1 reset state"));

    // R2: load both flavours
    apply(2'd0, 1'b0, 31, 0, 300, 0, "R2 load");
    // R3: first cycle subtracts from the stored value, then from the accumulator
    apply(2'd1, 1'b1, 31, 256, 32, 0, "R3 mac first");
    apply(2'd1, 1'b0, 31, -128, 16, 0, "R3 mac next");
    // R6: scale by one half, R11 psum untouched
    apply(2'd3, 1'b0, 31, 0, 4096, 0, "R6 R11 scale");
    // R5 R7: norm chaining, bottom row uses 7 fractional bits
    apply(2'd2, 1'b0, 31, 0, 0, 100, "R5 R7 norm");
    idle(2'd2, 555, "R9 idle");
    // R4: own value used in the matching column (off cell col 2, then diag col 1)
    apply(2'd1, 1'b1, 2, 1000, 40, 0, "R4 own col2");
    apply(2'd1, 1'b0, 1, 1000, 40, 0, "R4 own col1");
    apply(2'd1, 1'b0, 0, 1000, -24, 0, "R4 own col0");
    apply(2'd3, 1'b0, 31, 0, 8191, 0, "R4 R6 scale");
    apply(2'd2, 1'b0, 31, 0, 0, -50, "R5 norm neg chain");
    // R7: exact half rounds upward
    apply(2'd0, 1'b0, 31, 0, -20, 0, "R2 reload");
    apply(2'd1, 1'b1, 31, 1, 16, 0, "R7 half up");
    apply(2'd1, 1'b0, 31, -3, 16, 0, "R7 neg half");
    apply(2'd3, 1'b0, 31, 0, 8191, 0, "R7 scale out");
    idle(2'd3, 0, "R9 idle scale");
    // R8: saturation at both limits
    apply(2'd0, 1'b0, 31, 0, 8000, 0, "R8 load");
    apply(2'd1, 1'b1, 31, 8191, -1000, 0, "R8 mac high");
    apply(2'd2, 1'b0, 31, 0, 0, 8000, "R8 norm sat");
    apply(2'd3, 1'b0, 31, 0, 8191, 0, "R8 scale high");
    apply(2'd1, 1'b1, 31, 8191, 1000, 0, "R8 mac low");
    apply(2'd3, 1'b0, 31, 0, 8191, 0, "R8 scale low");
    apply(2'd3, 1'b0, 31, 0, -8192, 0, "R8 scale neg one");
    idle(2'd0, 0, "R9 R11 final idle");
    repeat (4) @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule